// File: doc/BRIEF.md
# Linear Image Sensor Scan Controller

This controller runs a 64-pixel linear image sensor whose readout is started by a serial start bit and stepped by a clock. It works from a fast system clock, which it divides into the sensor clock. It places the start bit around the first rising edge of each frame and runs a fixed number of sensor clocks per frame, so the start-to-start interval sets the integration time. For each of the 64 pixel edges it raises one ADC sample strobe, a programmed number of system clocks after the edge, together with the pixel index. A frame-valid level covers the readout and a done pulse marks the terminating edge.

Three configuration inputs set the half-period of the sensor clock, the frame length in sensor clocks and the settle delay, all counted in system clocks or sensor clocks. Each is clamped to a legal range. All three are captured only at a frame boundary. The first frame after reset is a flush: it clocks the sensor fully but produces no strobes. While `run` is low the sensor clock rests low. A status output flags a configuration whose frame period would exceed the longest allowed integration time.

Top module: `lsc_scan_ctrl`

## Requirements
- R1: During and right after reset, sen_clk, sen_si, adc_strobe, frame_valid, frame_done and period_err are 0 and pix_idx is 0.
- R2: sen_si rises only while sen_clk is low, is high at the first rising edge of a frame, and falls 2 system clocks after that edge, so it is low at the next rising edge.
- R3: sen_clk high and low phases each last H system clocks, with H = max(cfg_half, 20). Each frame has exactly P rising edges, with P = max(cfg_period, 66).
- R4: Each non-flush frame yields 64 single-cycle strobes, one after each of rising edges 1 to 64, with pix_idx = edge number minus 1. Each strobe comes S system clocks after its edge, with S = cfg_settle clamped to the range 37 to 2H-1. Edges 65 and later yield no strobe.
- R5: frame_done is a one-cycle pulse that coincides with rising edge 65 of each non-flush frame. It is never high at any other time.
- R6: frame_valid is high from rising edge 1 up to, but not including, rising edge 65 of each non-flush frame.
- R7: The first frame after reset runs full length with the start bit but gives no strobe, no frame_valid and no frame_done. Frames that follow an idle stretch are not flushed.
- R8: While run is low and no frame is in progress, sen_clk stays low. Dropping run mid-frame lets the frame complete all P edges first.
- R9: A change to cfg_half, cfg_period or cfg_settle during a frame has no effect until the next frame starts.
- R10: period_err is 1, one system clock after the inputs change, exactly when P*2*H exceeds 20,000,000 system clocks (100 ms at 200 MHz). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Keep framing while high |
| cfg_half | input | 8 | Sensor clock half-period in system clocks |
| cfg_period | input | 16 | Frame length in sensor clocks |
| cfg_settle | input | 9 | Delay from rising edge to strobe in system clocks |
| sen_clk | output | 1 | Sensor clock |
| sen_si | output | 1 | Sensor start bit |
| adc_strobe | output | 1 | ADC sample strobe, one system clock wide |
| pix_idx | output | 6 | Pixel index for the current strobe |
| frame_valid | output | 1 | Readout window of a non-flush frame |
| frame_done | output | 1 | Pulse at the terminating edge |
| period_err | output | 1 | Programmed frame period exceeds the integration limit |

## Verification
The hardest case to reach from the ports is a configuration change that lands in the middle of a frame. For that case the bench must show that the clock width, frame length and strobe delay all hold their old values until the exact boundary edge. The stimulus therefore waits for a detected frame start and then changes all three inputs several hundred cycles later. One of these changes uses values below the floors and above the settle ceiling, so the clamps are tested at the same boundary. The bench also drops run in mid-frame and checks that the remaining edges still arrive before the clock parks. It then restarts and checks that the restarted frame is not treated as a flush.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

  // raise a value to its floor
  function automatic int unsigned floor_to(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // settle delay must land after the floor and before the next rising edge
  function automatic int unsigned fit_settle(input int unsigned s, input int unsigned lo,
                                             input int unsigned half);
    int unsigned hi;
    int unsigned r;
    hi = 2 * half - 1;
    r  = (s < lo) ? lo : s;
    return (r > hi) ? hi : r;
  endfunction

  // frame period in system clocks against the integration ceiling
  function automatic logic over_limit(input int unsigned per, input int unsigned half,
                                      input int unsigned lim);
    longint unsigned t;
    t = longint'(per) * 2 * longint'(half);
    return t > longint'(lim);
  endfunction

  // readout window: from the high phase of cycle 1 to the low phase of cycle npix+1
  function automatic logic in_readout(input int unsigned cyc, input logic hi,
                                      input int unsigned npix);
    return hi ? (cyc >= 1 && cyc <= npix) : (cyc >= 2 && cyc <= npix + 1);
  endfunction

endpackage

// File: rtl/lsc_phase.sv
module lsc_phase #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] half,
  output logic [HW:0]   phase,
  output logic          clk_hi,
  output logic          at_rise,
  output logic          at_end
);
  localparam int PHW = HW + 1;

  logic [PHW-1:0] phase_q;
  logic [PHW-1:0] half_x;
  logic [PHW-1:0] last_x;

  assign half_x = {1'b0, half};
  assign last_x = (half_x << 1) - PHW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase_q <= '0;
    else if (!en)             phase_q <= '0;
    else if (phase_q == last_x) phase_q <= '0;
    else                      phase_q <= phase_q + PHW'(1);
  end

  assign phase   = phase_q;
  assign clk_hi  = en && (phase_q >= half_x);
  assign at_rise = en && (phase_q == half_x);
  assign at_end  = en && (phase_q == last_x);

  // R3: the counter never leaves one sensor period
  a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (phase_q <= last_x));
endmodule

// File: rtl/lsc_frame.sv
module lsc_frame #(
  parameter int NPIX = 64,
  parameter int HW   = 8,
  parameter int PW   = 16,
  parameter int SW   = 9,
  parameter int HOLD = 2,
  parameter int MIN_PER = 66
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run,
  input  logic [HW:0]               phase,
  input  logic                      at_rise,
  input  logic                      at_end,
  input  logic [HW-1:0]             half_sh,
  input  logic [PW-1:0]             per_sh,
  input  logic [SW-1:0]             settle_sh,
  output logic                      active,
  output logic                      load,
  output logic                      si,
  output logic                      strobe,
  output logic [$clog2(NPIX)-1:0]   idx,
  output logic                      fvalid,
  output logic                      done
);
  localparam int IW = $clog2(NPIX);

  logic          active_q, flush_q, arm_q;
  logic [PW-1:0] cyc_q;
  logic [SW:0]   since_q;
  logic [IW-1:0] idx_q;
  logic          last_cyc, frame_end;

  assign last_cyc  = (cyc_q == per_sh);
  assign frame_end = at_end && last_cyc;
  assign load      = run && (!active_q || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      flush_q  <= 1'b1;
      cyc_q    <= PW'(1);
    end else if (!active_q) begin
      if (run) begin
        active_q <= 1'b1;
        cyc_q    <= PW'(1);
      end
    end else if (at_end) begin
      if (last_cyc) begin
        cyc_q   <= PW'(1);
        flush_q <= 1'b0;
        if (!run) active_q <= 1'b0;
      end else begin
        cyc_q <= cyc_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      arm_q   <= 1'b0;
      idx_q   <= '0;
    end else if (at_rise) begin
      since_q <= (SW+1)'(1);
      arm_q   <= !flush_q && (cyc_q >= PW'(1)) && (cyc_q <= PW'(NPIX));
      idx_q   <= IW'(cyc_q - PW'(1));
    end else begin
      if (since_q != '1) since_q <= since_q + (SW+1)'(1);
      if (strobe) arm_q <= 1'b0;
    end
  end

  assign active = active_q;
  assign idx    = idx_q;
  assign strobe = arm_q && (since_q == {1'b0, settle_sh});
  assign si     = active_q && (cyc_q == PW'(1)) &&
                  (phase < ({1'b0, half_sh} + (HW+1)'(HOLD)));
  assign done   = at_rise && !flush_q && (cyc_q == PW'(NPIX + 1));
  assign fvalid = active_q && !flush_q &&
                  lsc_pkg::in_readout(32'(cyc_q), phase >= {1'b0, half_sh}, NPIX);

  // R3: the cycle count stays inside the clamped frame length
  a_r3_cycle_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cyc_q >= PW'(1) && cyc_q <= per_sh && per_sh >= PW'(MIN_PER)));
  // R4: every strobe is issued before the following rising edge
  a_r4_strobe_in_time: assert property (@(posedge clk) disable iff (!rst_n)
    at_rise |-> !arm_q);
  // R7: the flush frame is silent
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> (!strobe && !done && !fvalid));
endmodule

// File: rtl/lsc_scan_ctrl.sv
module lsc_scan_ctrl #(
  parameter int NPIX       = 64,
  parameter int HW         = 8,
  parameter int PW         = 16,
  parameter int MIN_HALF   = 20,
  parameter int MIN_SETTLE = 37,
  parameter int SI_HOLD    = 2,
  parameter int unsigned PERIOD_LIMIT = 20_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [HW-1:0]           cfg_half,
  input  logic [PW-1:0]           cfg_period,
  input  logic [HW:0]             cfg_settle,
  output logic                    sen_clk,
  output logic                    sen_si,
  output logic                    adc_strobe,
  output logic [$clog2(NPIX)-1:0] pix_idx,
  output logic                    frame_valid,
  output logic                    frame_done,
  output logic                    period_err
);
  localparam int SW      = HW + 1;
  localparam int IW      = $clog2(NPIX);
  localparam int MIN_PER = NPIX + 2;

  logic [HW-1:0] half_eff, half_sh;
  logic [PW-1:0] per_eff, per_sh;
  logic [SW-1:0] settle_eff, settle_sh;
  logic          err_w;

  assign half_eff   = HW'(lsc_pkg::floor_to(32'(cfg_half), MIN_HALF));
  assign per_eff    = PW'(lsc_pkg::floor_to(32'(cfg_period), MIN_PER));
  assign settle_eff = SW'(lsc_pkg::fit_settle(32'(cfg_settle), MIN_SETTLE, 32'(half_eff)));
  assign err_w      = lsc_pkg::over_limit(32'(per_eff), 32'(half_eff), PERIOD_LIMIT);

  logic          frm_active, frm_load;
  logic [HW:0]   phase;
  logic          clk_hi, at_rise, at_end;
  logic          si_w, stb_w, fv_w, done_w;
  logic [IW-1:0] idx_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_sh   <= HW'(MIN_HALF);
      per_sh    <= PW'(MIN_PER);
      settle_sh <= SW'(MIN_SETTLE);
    end else if (frm_load) begin
      half_sh   <= half_eff;
      per_sh    <= per_eff;
      settle_sh <= settle_eff;
    end
  end

  lsc_phase #(.HW(HW)) u_phase (
    .clk(clk), .rst_n(rst_n), .en(frm_active), .half(half_sh),
    .phase(phase), .clk_hi(clk_hi), .at_rise(at_rise), .at_end(at_end)
  );

  lsc_frame #(.NPIX(NPIX), .HW(HW), .PW(PW), .SW(SW), .HOLD(SI_HOLD),
              .MIN_PER(MIN_PER)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(run), .phase(phase), .at_rise(at_rise),
    .at_end(at_end), .half_sh(half_sh), .per_sh(per_sh), .settle_sh(settle_sh),
    .active(frm_active), .load(frm_load), .si(si_w), .strobe(stb_w),
    .idx(idx_w), .fvalid(fv_w), .done(done_w)
  );

  // registered pins: glitch-free, one uniform cycle of latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sen_clk     <= 1'b0;
      sen_si      <= 1'b0;
      adc_strobe  <= 1'b0;
      pix_idx     <= '0;
      frame_valid <= 1'b0;
      frame_done  <= 1'b0;
      period_err  <= 1'b0;
    end else begin
      sen_clk     <= clk_hi;
      sen_si      <= si_w;
      adc_strobe  <= stb_w;
      if (stb_w) pix_idx <= idx_w;
      frame_valid <= fv_w;
      frame_done  <= done_w;
      period_err  <= err_w;
    end
  end

  // R8: no frame in progress means the sensor clock rests low
  a_r8_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_active |=> !sen_clk);
  // R2: start bit rises only during a low clock phase
  a_r2_si_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sen_si) |-> !sen_clk);
  // R9: shadow configuration only moves at a frame boundary
  a_r9_hold_config: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_active && !frm_load) |=> ($stable(half_sh) && $stable(per_sh) && $stable(settle_sh)));
  // R5: done is a single-cycle pulse
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R4: strobes are single-cycle
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    adc_strobe |=> !adc_strobe);
endmodule

// File: tb/sim_lsc_scan_ctrl.sv
module sim_lsc_scan_ctrl;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [7:0]  cfg_half = 8'd20;
  logic [15:0] cfg_period = 16'd66;
  logic [8:0]  cfg_settle = 9'd37;
  logic sen_clk, sen_si, adc_strobe, frame_valid, frame_done, period_err;
  logic [5:0] pix_idx;

  always #2.5 clk = ~clk;

  lsc_scan_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_half(cfg_half),
    .cfg_period(cfg_period), .cfg_settle(cfg_settle), .sen_clk(sen_clk),
    .sen_si(sen_si), .adc_strobe(adc_strobe), .pix_idx(pix_idx),
    .frame_valid(frame_valid), .frame_done(frame_done), .period_err(period_err)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // scoreboard of expected strobes
  int exp_idx[$];
  int exp_dly[$];

  task automatic push_frame(input int settle);
    for (int k = 0; k < 64; k++) begin
      exp_idx.push_back(k);
      exp_dly.push_back(settle);
    end
  endtask

  // expected configuration: next_* follow the inputs, cur_* apply per frame
  int next_half = 20, next_per = 66, next_settle = 37;
  int cur_half = 20, cur_per = 66, cur_settle = 37;
  int edges = 0, frame_no = 0, rises = 0, n_strobe = 0;
  int since = 0, hi_len = 0, lo_len = 0, last_hi = 0;
  logic pclk = 1'b0, psi = 1'b0;
  event ev_start;

  // monitor: samples on the falling system edge
  always @(negedge clk) if (rst_n) begin
    if (sen_clk && !pclk) begin
      rises++;
      since = 0;
      if (sen_si) begin
        if (frame_no > 0) chk(edges == cur_per, "R3 edges per frame", edges, cur_per);
        frame_no++;
        cur_half = next_half; cur_per = next_per; cur_settle = next_settle;
        edges = 1;
        if (frame_no >= 2) push_frame(cur_settle);
        -> ev_start;
      end else begin
        edges++;
        chk(lo_len == cur_half, "R3 low phase", lo_len, cur_half);
      end
      chk(frame_valid == (frame_no >= 2 && edges <= 64), "R6 frame_valid at edge",
          int'(frame_valid), int'(frame_no >= 2 && edges <= 64));
      chk(frame_done == (frame_no >= 2 && edges == 65), "R5 done at edge",
          int'(frame_done), int'(frame_no >= 2 && edges == 65));
      hi_len = 1; lo_len = 0;
    end else if (!sen_clk && pclk) begin
      since++;
      chk(hi_len == cur_half, "R3 high phase", hi_len, cur_half);
      last_hi = hi_len;
      lo_len = 1;
    end else begin
      since++;
      if (sen_clk) hi_len++; else lo_len++;
      if (frame_done) chk(0, "R5 done off edge", 1, 0);
    end
    if (adc_strobe) begin
      n_strobe++;
      if (exp_idx.size() == 0) chk(0, "R4 R7 unexpected strobe", int'(pix_idx), -1);
      else begin
        int ei, ed;
        ei = exp_idx.pop_front();
        ed = exp_dly.pop_front();
        chk(int'(pix_idx) == ei, "R4 pixel index", int'(pix_idx), ei);
        chk(since == ed, "R4 settle delay", since, ed);
      end
    end
    if (sen_si && !psi && sen_clk) chk(0, "R2 start rose while clock high", 1, 0);
    if (psi && !sen_si) chk(since == HOLD, "R2 start fall time", since, HOLD);
    pclk = sen_clk;
    psi  = sen_si;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    int s0, r0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk({sen_clk, sen_si, adc_strobe, frame_valid, frame_done, period_err} == 6'b0,
        "R1 outputs in reset", int'({sen_clk, sen_si, adc_strobe, frame_valid, frame_done, period_err}), 0);
    chk(pix_idx == 6'd0, "R1 pix_idx in reset", int'(pix_idx), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk({sen_clk, sen_si, frame_valid, frame_done, period_err} == 5'b0,
        "R1 outputs after reset", int'({sen_clk, sen_si, frame_valid, frame_done, period_err}), 0);
    repeat (50) @(negedge clk);
    chk(rises == 0 && !sen_clk, "R8 parked before run", rises, 0);

    run = 1'b1;
    @(ev_start); @(ev_start);
    chk(n_strobe == 0, "R7 flush frame silent", n_strobe, 0);
    @(ev_start);
    chk(n_strobe == 64, "R4 strobes per frame", n_strobe, 64);

    // R9: change mid-frame, old width must hold for the rest of the frame
    repeat (500) @(negedge clk);
    cfg_half = 8'd24; cfg_period = 16'd70; cfg_settle = 9'd10;
    next_half = 24; next_per = 70; next_settle = 37;
    r0 = rises;
    wait (rises >= r0 + 3);
    @(negedge clk);
    repeat (30) @(negedge clk);
    chk(last_hi == 20, "R9 old half kept", last_hi, 20);
    @(ev_start);
    repeat (200) @(negedge clk);
    chk(last_hi == 24, "R9 new half applied", last_hi, 24);
    @(ev_start);

    // clamps: half and period floors, settle ceiling
    repeat (400) @(negedge clk);
    cfg_half = 8'd5; cfg_period = 16'd10; cfg_settle = 9'd100;
    next_half = 20; next_per = 66; next_settle = 39;
    @(ev_start); @(ev_start);

    // R8: drop run mid-frame; the frame must finish, then the clock parks
    repeat (300) @(negedge clk);
    run = 1'b0;
    repeat (66 * 40 + 400) @(negedge clk);
    r0 = rises;
    repeat (200) @(negedge clk);
    chk(rises == r0 && !sen_clk, "R8 clock parked after run drop", rises - r0, 0);
    chk(edges == cur_per, "R8 frame completed before park", edges, cur_per);
    chk(exp_idx.size() == 0, "R4 all strobes delivered", exp_idx.size(), 0);

    // R10 limit boundary: 510*39215 = 19,999,650 ; 510*39216 = 20,000,160
    cfg_half = 8'd255; cfg_period = 16'd39215;
    repeat (2) @(negedge clk);
    chk(period_err == 1'b0, "R10 just under limit", int'(period_err), 0);
    cfg_period = 16'd39216;
    repeat (2) @(negedge clk);
    chk(period_err == 1'b1, "R10 just over limit", int'(period_err), 1);
    cfg_half = 8'd20; cfg_period = 16'd66; cfg_settle = 9'd37;
    next_half = 20; next_per = 66; next_settle = 37;
    repeat (2) @(negedge clk);
    chk(period_err == 1'b0, "R10 cleared", int'(period_err), 0);

    // R7: restart after idle is a normal frame
    run = 1'b1;
    @(ev_start);
    s0 = n_strobe;
    @(ev_start);
    chk(n_strobe - s0 == 64, "R7 no flush after idle", n_strobe - s0, 64);
    repeat (100) @(negedge clk);
    run = 1'b0;
    repeat (66 * 40 + 400) @(negedge clk);
    chk(exp_idx.size() == 0, "R4 final strobes delivered", exp_idx.size(), 0);
    chk(!sen_clk && !sen_si, "R8 idle at end", int'({sen_clk, sen_si}), 0);
    finish_up();
  end
endmodule